// File: doc/BRIEF.md
# SPI Idle-Timeout Reset Watchdog

This block sits next to a SPI slave and watches its link from the master-clock domain. The chip select and the serial clock arrive with no fixed phase to the master clock. While chip select is held low, the block counts master-clock periods since the last sign of activity. That activity is the falling edge of chip select or any serial-clock transition, rising or falling. If the count reaches the configured limit, the block emits a one-cycle reset pulse. The slave's shift logic treats this pulse exactly like a release of chip select, so a stalled transfer cannot hang the interface.

Both asynchronous inputs pass through a multi-stage synchronizer. Serial-clock edges are found by comparing consecutive synchronized samples, so a rising and a falling transition each restart the count. The serial clock may toggle at most once per master-clock period, which is half the master-clock rate. At that rate every transition survives synchronization and reaches the counter within two master-clock cycles of being sampled. A single configuration input chooses between a short limit of 256 periods and a long limit of 4096 periods. The long limit applies when the input is low.

Top module: `spi_idle_watchdog`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `spi_reset_pulse` is 0.
- R2: While chip select is high, no pulse is produced, however long it stays high.
- R3: With `short_timeout` = 1, an input change at chip-select fall followed by no serial-clock activity yields a pulse that goes high after the 259th master-clock rising edge following the change. That is the limit of 256 plus 3 cycles of synchronizer and edge-detect latency.
- R4: With `short_timeout` = 0, the same idle case yields a pulse after the 4099th rising edge, from a limit of 4096 plus 3 cycles.
- R5: Every serial-clock transition, rising or falling, restarts the count. The pulse timing of R3 and R4 is then measured from the last transition.
- R6: For any phase between the serial clock and the master clock, a continuous transfer produces no pulse. This holds for edges one master period apart and for edges spaced up to 253 periods apart with the short limit. A true idle period that follows still produces the pulse at the R3 cycle.
- R7: At most one pulse is produced per chip-select-low period, and later idle time or serial-clock edges do not re-arm it. A fresh fall of chip select re-arms it.
- R8: Releasing chip select before the limit is reached cancels the count, and no pulse follows.
- R9: The pulse is exactly one master-clock cycle wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_async | input | 1 | Serial clock, asynchronous to `clk` |
| cs_n_async | input | 1 | Active-low chip select, asynchronous to `clk` |
| short_timeout | input | 1 | 1 selects the 256-period limit, 0 the 4096-period limit |
| spi_reset_pulse | output | 1 | One-cycle reset request to the SPI slave logic |

## Verification
The idle case is run with both limits and checked at the exact expected cycle, which separates a correct limit from an off-by-one and from a mixed-up selection. Alternating rising and falling transitions separated by long gaps show that both edge directions restart the count. A phase sweep runs ten sub-cycle offsets, each with a burst at the fastest legal rate and then a slow continuous transfer. This exposes lost edges and false timeouts that appear only at particular phases. Further scenarios cover a chip-select release mid-count, and idle time and edges after a timeout, to separate cancellation, single-shot behaviour and re-arming.

// File: rtl/idle_wdt_pkg.sv
package idle_wdt_pkg;

  typedef enum logic {
    TMO_LONG  = 1'b0,
    TMO_SHORT = 1'b1
  } tmo_mode_e;

  function automatic int cnt_width(input int limit);
    return (limit > 2) ? $clog2(limit) : 1;
  endfunction

endpackage

// File: rtl/idle_wdt_sync.sv
module idle_wdt_sync #(
  parameter int              WIDTH   = 2,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= RST_VAL;
        else     chain[s] <= d_async;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= RST_VAL;
        else     chain[s] <= chain[s-1];
      end
    end
  end

  assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/idle_wdt_edges.sv
module idle_wdt_edges (
  input  logic clk,
  input  logic rst,
  input  logic sclk_s,
  input  logic cs_n_s,
  output logic sclk_edge,
  output logic cs_fall,
  output logic cs_low
);

  logic sclk_prev;
  logic cs_n_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_prev <= 1'b0;
      cs_n_prev <= 1'b1;
    end else begin
      sclk_prev <= sclk_s;
      cs_n_prev <= cs_n_s;
    end
  end

  // A change in either direction counts as activity.
  assign sclk_edge = sclk_s ^ sclk_prev;
  assign cs_fall   = cs_n_prev & ~cs_n_s;
  assign cs_low    = ~cs_n_s;

endmodule

// File: rtl/idle_wdt_timer.sv
module idle_wdt_timer
  import idle_wdt_pkg::*;
#(
  parameter int SHORT_LIMIT = 256,
  parameter int LONG_LIMIT  = 4096,
  localparam int MAX_LIMIT  = (LONG_LIMIT > SHORT_LIMIT) ? LONG_LIMIT : SHORT_LIMIT,
  localparam int CNT_W      = cnt_width(MAX_LIMIT)
) (
  input  logic      clk,
  input  logic      rst,
  input  tmo_mode_e mode,
  input  logic      cs_low,
  input  logic      restart,
  output logic      fire
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim_m1;
  logic             armed;

  assign lim_m1 = (mode == TMO_SHORT) ? CNT_W'(SHORT_LIMIT - 1)
                                      : CNT_W'(LONG_LIMIT - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      armed <= 1'b1;
      fire  <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (!cs_low) begin
        cnt   <= '0;
        armed <= 1'b1;
      end else if (restart) begin
        cnt <= '0;
      end else if (armed) begin
        if (cnt == lim_m1) begin
          fire  <= 1'b1;
          armed <= 1'b0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/spi_idle_watchdog.sv
module spi_idle_watchdog
  import idle_wdt_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int SHORT_LIMIT = 256,
  parameter int LONG_LIMIT  = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_async,
  input  logic cs_n_async,
  input  logic short_timeout,
  output logic spi_reset_pulse
);

  logic [1:0] sync_q;
  logic       sclk_edge;
  logic       cs_fall;
  logic       cs_low;
  tmo_mode_e  mode;

  assign mode = short_timeout ? TMO_SHORT : TMO_LONG;

  idle_wdt_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES),
    .RST_VAL(2'b10)
  ) sync_i (
    .clk    (clk),
    .rst    (rst),
    .d_async({cs_n_async, sclk_async}),
    .q_sync (sync_q)
  );

  idle_wdt_edges edges_i (
    .clk      (clk),
    .rst      (rst),
    .sclk_s   (sync_q[0]),
    .cs_n_s   (sync_q[1]),
    .sclk_edge(sclk_edge),
    .cs_fall  (cs_fall),
    .cs_low   (cs_low)
  );

  idle_wdt_timer #(
    .SHORT_LIMIT(SHORT_LIMIT),
    .LONG_LIMIT (LONG_LIMIT)
  ) timer_i (
    .clk    (clk),
    .rst    (rst),
    .mode   (mode),
    .cs_low (cs_low),
    .restart(sclk_edge | cs_fall),
    .fire   (spi_reset_pulse)
  );

endmodule

// File: rtl/spi_idle_watchdog_chk.sv
module spi_idle_watchdog_chk #(
  parameter int SHORT_LIMIT = 256,
  parameter int LONG_LIMIT  = 4096,
  localparam int GAP_W      = $clog2(LONG_LIMIT + SHORT_LIMIT + 2)
) (
  input logic clk,
  input logic rst,
  input logic short_timeout,
  input logic cs_low,
  input logic cs_fall,
  input logic sclk_edge,
  input logic spi_reset_pulse
);

  logic [GAP_W-1:0] gap;
  logic [GAP_W-1:0] gap_lim;
  logic             fired;

  assign gap_lim = short_timeout ? GAP_W'(SHORT_LIMIT - 1) : GAP_W'(LONG_LIMIT - 1);

  always_ff @(posedge clk) begin
    if (rst || !cs_low || sclk_edge || cs_fall) gap <= '0;
    else if (gap != '1)                         gap <= gap + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !cs_low)      fired <= 1'b0;
    else if (spi_reset_pulse) fired <= 1'b1;
  end

  assert_quiet_in_reset_R1: assert property (@(posedge clk)
    rst |=> !spi_reset_pulse);

  assert_no_pulse_cs_high_R2: assert property (@(posedge clk) disable iff (rst)
    $past(!cs_low) |-> !spi_reset_pulse);

  assert_limit_gap_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_reset_pulse) |-> ($past(gap) == $past(gap_lim)));

  assert_edge_restarts_R5: assert property (@(posedge clk) disable iff (rst)
    sclk_edge |=> !spi_reset_pulse);

  assert_single_shot_R7: assert property (@(posedge clk) disable iff (rst)
    fired |-> !spi_reset_pulse);

  assert_one_cycle_R9: assert property (@(posedge clk) disable iff (rst)
    spi_reset_pulse |=> !spi_reset_pulse);

endmodule

bind spi_idle_watchdog spi_idle_watchdog_chk #(
  .SHORT_LIMIT(SHORT_LIMIT),
  .LONG_LIMIT (LONG_LIMIT)
) chk_i (
  .clk            (clk),
  .rst            (rst),
  .short_timeout  (short_timeout),
  .cs_low         (cs_low),
  .cs_fall        (cs_fall),
  .sclk_edge      (sclk_edge),
  .spi_reset_pulse(spi_reset_pulse)
);

// File: tb/spi_idle_watchdog_tb_top.sv
module spi_idle_watchdog_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  localparam realtime CLK_PERIOD = 10.0;
  localparam int SHORT_LIM = 256;
  localparam int LONG_LIM  = 4096;
  localparam int LAT       = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0;
  logic cs_n = 1'b1;
  logic short_sel = 1'b0;
  logic pulse;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int pulse_cnt = 0;
  int last_pulse_cyc = -1;
  int wide_err = 0;
  logic prev_pulse = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2.0) clk = ~clk;

  spi_idle_watchdog dut_i (
    .clk            (clk),
    .rst            (rst),
    .sclk_async     (sclk),
    .cs_n_async     (cs_n),
    .short_timeout  (short_sel),
    .spi_reset_pulse(pulse)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (pulse === 1'b1) begin
      pulse_cnt      <= pulse_cnt + 1;
      last_pulse_cyc <= cyc;
      if (prev_pulse) wide_err <= wide_err + 1;
    end
    prev_pulse <= (pulse === 1'b1);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
  endtask

  // Move to a point off (ns) after a rising edge.
  task automatic at_offset(input realtime off);
    @(posedge clk);
    #(off);
  endtask

  task automatic release_cs();
    at_offset(3.0);
    cs_n = 1'b1;
    cycles(6);
  endtask

  task automatic t_reset();
    cycles(4);
    @(negedge clk);
    check(pulse === 1'b0, "R1 pulse during reset", int'(pulse), 0);
    rst = 1'b0;
    @(negedge clk);
    check(pulse === 1'b0, "R1 pulse after reset", int'(pulse), 0);
  endtask

  task automatic t_cs_high_quiet();
    int base;
    short_sel = 1'b1;
    base = pulse_cnt;
    cycles(700);
    @(negedge clk);
    check(pulse_cnt == base, "R2 pulses with chip select high", pulse_cnt - base, 0);
  endtask

  task automatic t_idle(input bit shrt, input realtime off, input string req);
    int base, ev, lim;
    short_sel = shrt;
    lim = shrt ? SHORT_LIM : LONG_LIM;
    cycles(2);
    base = pulse_cnt;
    at_offset(off);
    cs_n = 1'b0;
    ev = cyc;
    cycles(lim + LAT + 20);
    @(negedge clk);
    check(pulse_cnt - base == 1, {req, " pulse count"}, pulse_cnt - base, 1);
    check(last_pulse_cyc == ev + lim + LAT, {req, " pulse cycle"}, last_pulse_cyc - ev, lim + LAT);
    release_cs();
  endtask

  task automatic t_restart();
    int base, ev;
    short_sel = 1'b1;
    base = pulse_cnt;
    at_offset(2.5);
    cs_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      cycles(240);
      #(4.5);
      sclk = ~sclk;
      ev = cyc;
    end
    @(negedge clk);
    check(pulse_cnt == base, "R5 no pulse while edges restart", pulse_cnt - base, 0);
    cycles(SHORT_LIM + LAT + 20);
    @(negedge clk);
    check(pulse_cnt - base == 1, "R5 pulse after last edge", pulse_cnt - base, 1);
    check(last_pulse_cyc == ev + SHORT_LIM + LAT, "R5 pulse cycle after last edge",
          last_pulse_cyc - ev, SHORT_LIM + LAT);
    sclk = 1'b0;
    release_cs();
  endtask

  task automatic t_phase_sweep();
    short_sel = 1'b1;
    for (int k = 0; k < 10; k++) begin
      realtime off;
      int base, ev;
      off = 0.5 + real'(k);
      base = pulse_cnt;
      at_offset(off);
      cs_n = 1'b0;
      ev = cyc;
      for (int i = 0; i < 16; i++) begin
        #(11.0);
        sclk = ~sclk;
        ev = cyc;
      end
      for (int i = 0; i < 20; i++) begin
        #(2530.0 + off / 10.0);
        sclk = ~sclk;
        ev = cyc;
      end
      @(negedge clk);
      check(pulse_cnt == base, "R6 false timeout during transfer", pulse_cnt - base, 0);
      cycles(SHORT_LIM + LAT + 20);
      @(negedge clk);
      check(pulse_cnt - base == 1 && last_pulse_cyc == ev + SHORT_LIM + LAT,
            "R6 idle timeout cycle after sweep transfer", last_pulse_cyc - ev, SHORT_LIM + LAT);
      release_cs();
    end
  endtask

  task automatic t_once_rearm();
    int base, ev;
    short_sel = 1'b1;
    base = pulse_cnt;
    at_offset(6.0);
    cs_n = 1'b0;
    cycles(SHORT_LIM + 300);
    at_offset(3.0);
    sclk = ~sclk;
    cycles(SHORT_LIM + 300);
    @(negedge clk);
    check(pulse_cnt - base == 1, "R7 single pulse per low period", pulse_cnt - base, 1);
    release_cs();
    at_offset(7.0);
    cs_n = 1'b0;
    ev = cyc;
    cycles(SHORT_LIM + LAT + 20);
    @(negedge clk);
    check(pulse_cnt - base == 2 && last_pulse_cyc == ev + SHORT_LIM + LAT,
          "R7 re-armed by new chip select fall", last_pulse_cyc - ev, SHORT_LIM + LAT);
    release_cs();
  endtask

  task automatic t_cancel();
    int base;
    short_sel = 1'b1;
    base = pulse_cnt;
    at_offset(1.5);
    cs_n = 1'b0;
    cycles(200);
    at_offset(1.5);
    cs_n = 1'b1;
    cycles(SHORT_LIM + 200);
    @(negedge clk);
    check(pulse_cnt == base, "R8 pulse after early release", pulse_cnt - base, 0);
  endtask

  initial begin
    t_reset();
    t_cs_high_quiet();
    t_idle(1'b1, 2.0, "R3 short limit");
    t_idle(1'b1, 8.5, "R3 short limit late phase");
    t_idle(1'b0, 4.0, "R4 long limit");
    t_restart();
    t_phase_sweep();
    t_once_rearm();
    t_cancel();
    check(wide_err == 0, "R9 pulse wider than one cycle", wide_err, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000.0);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule